// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a single-word SPI master placed behind a small 16-bit register port. Software programs a control word with the enable, the word length, the clock mode, the interrupt enables and a clock divider. It then writes the word to transmit into the data register. The block shifts that word out on `mosi_o`, MSB first, while it toggles `sclk_o`. At the same time it shifts in the word from `miso_i` and keeps it until the host reads it back.

A status register reports two flags: a busy flag for a shift in progress and a flag for an unread received word. One registered, level-sensitive interrupt line combines these two flags under two separate enables. Chip-select generation is handled outside the block. There is no buffering: one word is in flight at a time. A host that only wants to receive writes zero to the data register to start clocking.

Top module: `spi_reg_master`

## Requirements
- R1: The registers sit at byte offsets data = 0x0, control = 0x2 and status = 0x4. Control reads back only its defined bits: enable bit 0, word size bit 2, receive interrupt enable bit 5, ready interrupt enable bit 6, mode bits 7 and 8, and divider bits 15:9. All other bits read 0. Writing 0xFFFF therefore reads back 0xFFE5. Status bit 0 is busy and status bit 1 is receive-full; all other status bits read 0. After reset every register reads 0, `sclk_o` is 0 and `irq_o` is 0.
- R2: A data write with enable set and busy clear starts one transfer and sets busy until the last clock edge of the word. A data write with enable clear starts nothing.
- R3: A data write while busy is ignored. The word on `mosi_o` and the word received are those of the transfer already running.
- R4: Control bit 2 selects 16-bit words when set and 8-bit words when clear. Data goes out MSB first. In 8-bit mode only bits 7:0 of the written value are sent.
- R5: Control bit 7 is the clock polarity: `sclk_o` idles at the value of bit 7. Control bit 8 is the clock phase. So mode 0 has both bits clear, mode 1 sets only bit 8, mode 2 sets only bit 7, and mode 3 sets both.
- R6: With phase 0, `miso_i` is sampled on the leading edge and `mosi_o` changes on the trailing edge. With phase 1, `mosi_o` changes on each leading edge after the first, and `miso_i` is sampled on the trailing edge. The received word is correct in all four modes.
- R7: Each half period of `sclk_o` lasts D+1 system clocks, where D is control bits 15:9. D=0 behaves exactly like D=1.
- R8: Receive-full sets when a word completes. A data read returns the received word right-aligned, with zero fill above bit 7 in 8-bit mode, and clears receive-full.
- R9: Clearing control bit 0 aborts any transfer: busy clears, `sclk_o` returns to its idle level and receive-full is not set.
- R10: One clock after the condition holds, `irq_o` equals (bit 5 AND receive-full) OR (bit 6 AND bit 0 AND NOT busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Register byte offset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (side effect on data read) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Transfers are run in all four clock modes, with both word sizes. The bench's slave model samples and drives on edges it derives only from the mode, so a swapped polarity or phase bit shows up as a corrupted word in one direction. Words with distinct high and low bytes separate truncation in 8-bit mode from a missing zero fill. Half-period counts at D=0, D=1 and D=5 separate a wrong divider formula from a missing clamp. A write during a transfer, an abort, and writes with the block disabled show that the shift state is left alone when it should be.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 7;
  localparam int ECNT_W = $clog2(2 * WORD_W);

  localparam int OFF_DATA = 0;
  localparam int OFF_CTRL = 2;
  localparam int OFF_STAT = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             wie;
    logic             rie;
    logic             wide;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/spi_reg_baud.sv
module spi_reg_baud
  import spi_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // zero is clamped to one: fastest ratio is 4
  assign lim    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_reg_shift.sv
module spi_reg_shift
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wide_i,
  input  logic              cpha_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_phase_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam logic [ECNT_W-1:0] LAST_WIDE   = ECNT_W'(2 * WORD_W - 1);
  localparam logic [ECNT_W-1:0] LAST_NARROW = ECNT_W'(2 * BYTE_W - 1);

  logic              busy_q, phase_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              lead, do_sample, do_shift, last_edge;
  logic [WORD_W-1:0] rx_next;

  assign lead      = ~phase_q;
  assign last_edge = ecnt_q == (wide_i ? LAST_WIDE : LAST_NARROW);
  assign do_sample = lead ^ cpha_i;
  assign do_shift  = cpha_i ? (lead && ecnt_q != '0) : !lead;
  assign rx_next   = {rx_q[WORD_W-2:0], miso_i};

  assign busy_o       = busy_q;
  assign sclk_phase_o = phase_q;
  assign mosi_o       = tx_q[WORD_W-1];
  assign done_o       = en_i && busy_q && tick_i && last_edge;
  // phase 1 takes its final sample on the last edge itself
  assign rx_word_o    = (cpha_i && do_sample) ? rx_next : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else if (!en_i) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      ecnt_q  <= '0;
      rx_q    <= '0;
      tx_q    <= wide_i ? tx_i : {tx_i[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
    end else if (busy_q && tick_i) begin
      phase_q <= ~phase_q;
      ecnt_q  <= ecnt_q + 1'b1;
      if (do_sample) rx_q <= rx_next;
      if (do_shift)  tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (last_edge) begin
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_reg_regs.sv
module spi_reg_regs
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic              rbf_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic              rbf_q, irq_q;
  logic [WORD_W-1:0] rx_buf_q;
  logic              sel_data, sel_ctrl, sel_stat;
  logic [WORD_W-1:0] ctrl_view;

  assign sel_data = bus_addr_i == ADDR_W'(OFF_DATA);
  assign sel_ctrl = bus_addr_i == ADDR_W'(OFF_CTRL);
  assign sel_stat = bus_addr_i == ADDR_W'(OFF_STAT);

  assign start_o = bus_we_i && sel_data && ctrl_q.en && !busy_i;

  assign ctrl_view = {ctrl_q.div, ctrl_q.cpha, ctrl_q.cpol, ctrl_q.wie, ctrl_q.rie,
                      2'b00, ctrl_q.wide, 1'b0, ctrl_q.en};

  always_comb begin
    bus_rdata_o = '0;
    if (sel_data)      bus_rdata_o = rx_buf_q;
    else if (sel_ctrl) bus_rdata_o = ctrl_view;
    else if (sel_stat) bus_rdata_o = {{(WORD_W-2){1'b0}}, rbf_q, busy_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (bus_we_i && sel_ctrl) begin
      ctrl_q.div  <= bus_wdata_i[15:9];
      ctrl_q.cpha <= bus_wdata_i[8];
      ctrl_q.cpol <= bus_wdata_i[7];
      ctrl_q.wie  <= bus_wdata_i[6];
      ctrl_q.rie  <= bus_wdata_i[5];
      ctrl_q.wide <= bus_wdata_i[2];
      ctrl_q.en   <= bus_wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbf_q    <= 1'b0;
      rx_buf_q <= '0;
    end else if (done_i) begin
      rbf_q    <= 1'b1;
      rx_buf_q <= ctrl_q.wide ? rx_word_i
                              : {{(WORD_W-BYTE_W){1'b0}}, rx_word_i[BYTE_W-1:0]};
    end else if (bus_re_i && sel_data) begin
      rbf_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (ctrl_q.rie && rbf_q) || (ctrl_q.wie && ctrl_q.en && !busy_i);
  end

  assign ctrl_o = ctrl_q;
  assign rbf_o  = rbf_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              busy_w, done_w, start_w, tick_w, phase_w, rbf_w;
  logic [WORD_W-1:0] rx_word_w;

  spi_reg_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .bus_re_i   (bus_re_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .busy_i     (busy_w),
    .done_i     (done_w),
    .rx_word_i  (rx_word_w),
    .ctrl_o     (ctrl),
    .start_o    (start_w),
    .rbf_o      (rbf_w),
    .irq_o      (irq_o)
  );

  spi_reg_baud i_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_w),
    .div_i (ctrl.div),
    .tick_o(tick_w)
  );

  spi_reg_shift i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl.en),
    .wide_i      (ctrl.wide),
    .cpha_i      (ctrl.cpha),
    .start_i     (start_w),
    .tx_i        (bus_wdata_i),
    .tick_i      (tick_w),
    .miso_i      (miso_i),
    .busy_o      (busy_w),
    .sclk_phase_o(phase_w),
    .mosi_o      (mosi_o),
    .done_o      (done_w),
    .rx_word_o   (rx_word_w)
  );

  assign sclk_o = ctrl.cpol ^ phase_w;
endmodule

// File: rtl/spi_reg_checker.sv
module spi_reg_checker
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic              sclk_o,
  input logic              irq_o,
  input logic              busy,
  input logic              rbf,
  input logic              en,
  input logic              cpol,
  input logic              rie,
  input logic              wie
);
  a_r2_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(bus_we_i && bus_addr_i == ADDR_W'(OFF_DATA) && en));

  a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !busy);

  a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sclk_o == cpol);

  a_r8_rbf_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rbf) |-> $fell(busy));

  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past((rie && rbf) || (wie && en && !busy)));
endmodule

bind spi_reg_master spi_reg_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_addr_i(bus_addr_i),
  .bus_we_i  (bus_we_i),
  .sclk_o    (sclk_o),
  .irq_o     (irq_o),
  .busy      (busy_w),
  .rbf       (rbf_w),
  .en        (ctrl.en),
  .cpol      (ctrl.cpol),
  .rie       (ctrl.rie),
  .wie       (ctrl.wie)
);

// File: tb/test_spi_reg_master.sv
`timescale 1ns/1ps
module test_spi_reg_master;
  localparam int A_DATA = 0, A_CTRL = 2, A_STAT = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0, miso = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, mosi, irq;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_reg_master i_spi_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic bus_wr(input int a, input logic [15:0] d);
    @(negedge clk); addr = 3'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = 3'(a); re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  // slave model
  logic        s_act = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_first = 1'b0;
  logic [15:0] s_tx = '0, s_rx = '0, mosi_got = '0;
  int          s_bits = 8, s_cnt = 0;

  task automatic arm(input int mode, input bit wide, input logic [15:0] sw);
    s_cpol = mode[1]; s_cpha = mode[0];
    s_bits = wide ? 16 : 8;
    s_tx = wide ? sw : {sw[7:0], 8'h00};
    s_rx = '0; s_cnt = 0; s_first = 1'b1;
    miso = s_tx[15];
    s_act = 1'b1;
  endtask

  always @(sclk) begin
    if (s_act) begin
      #1;
      if ((sclk != s_cpol) ^ s_cpha) begin
        s_rx = {s_rx[14:0], mosi};
        s_cnt++;
        if (s_cnt == s_bits) begin mosi_got = s_rx; s_act = 1'b0; end
      end else begin
        if (!(s_cpha && s_first)) s_tx = {s_tx[14:0], 1'b0};
        s_first = 1'b0;
        miso = s_tx[15];
      end
    end
  end

  // scoreboard
  typedef struct packed { logic [15:0] rx; logic [15:0] tx; } exp_t;
  exp_t q[$];

  initial begin
    forever begin
      logic [15:0] d;
      exp_t e;
      wait (q.size() > 0);
      wait (irq === 1'b1);
      bus_rd(A_DATA, d);
      e = q[0];
      chk(d == e.rx, "R6/R8 rx word", d, e.rx);
      chk(mosi_got == e.tx, "R4/R6 mosi word", mosi_got, e.tx);
      void'(q.pop_front());
    end
  end

  function automatic logic [15:0] ctrl_word(input bit en, input bit wide, input bit rie,
                                            input bit wie, input int mode, input int dv);
    return {7'(dv), mode[0], mode[1], wie, rie, 2'b00, wide, 1'b0, en};
  endfunction

  task automatic xfer(input int mode, input bit wide, input int dv,
                      input logic [15:0] tx, input logic [15:0] sw, input bit poke);
    exp_t e;
    logic [15:0] st;
    bus_wr(A_CTRL, ctrl_word(1, wide, 1, 0, mode, dv));
    arm(mode, wide, sw);
    e.rx = wide ? sw : {8'h00, sw[7:0]};
    e.tx = wide ? tx : {8'h00, tx[7:0]};
    q.push_back(e);
    bus_wr(A_DATA, tx);
    if (poke) begin
      repeat (6) @(negedge clk);
      bus_wr(A_DATA, 16'hFFFF); // R3 write while busy
    end
    wait (q.size() == 0);
    bus_rd(A_STAT, st);
    chk(st == 16'h0, "R8 rbf cleared by data read", st, 0);
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(A_STAT, st);
      if (st[0] == 1'b0) break;
    end
  endtask

  task automatic measure(input int dv, input int exp_half);
    int t0, t1;
    logic [15:0] d;
    bus_wr(A_CTRL, ctrl_word(1, 0, 0, 0, 0, dv));
    arm(0, 0, 16'h00);
    bus_wr(A_DATA, 16'h55);
    @(sclk); @(negedge clk); t0 = cyc;
    @(sclk); @(negedge clk); t1 = cyc;
    chk(t1 - t0 == exp_half, "R7 half period", t1 - t0, exp_half);
    wait_idle();
    bus_rd(A_DATA, d);
  endtask

  initial begin
    #(200000 * 20);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(A_CTRL, d); chk(d == 0, "R1 ctrl reset", d, 0);
    bus_rd(A_STAT, d); chk(d == 0, "R1 stat reset", d, 0);
    chk(irq == 0 && sclk == 0, "R1 irq/sclk reset", {irq, sclk}, 0);
    bus_wr(A_CTRL, 16'hFFFF);
    bus_rd(A_CTRL, d); chk(d == 16'hFFE5, "R1 ctrl readback", d, 16'hFFE5);
    bus_wr(A_CTRL, 16'h0000);

    // R2 data write while disabled starts nothing
    bus_wr(A_DATA, 16'h00A5);
    repeat (4) @(negedge clk);
    bus_rd(A_STAT, d); chk(d == 0, "R2 disabled write ignored", d, 0);

    // R5 idle levels
    bus_wr(A_CTRL, ctrl_word(1, 0, 0, 0, 2, 3));
    @(negedge clk); chk(sclk == 1, "R5 mode2 idle high", sclk, 1);
    bus_wr(A_CTRL, ctrl_word(1, 0, 0, 0, 1, 3));
    @(negedge clk); chk(sclk == 0, "R5 mode1 idle low", sclk, 0);

    // R4 R6 four modes, both sizes
    xfer(0, 0, 3, 16'hA5C3, 16'hFF5A, 0);
    xfer(1, 0, 2, 16'h0096, 16'h0069, 0);
    xfer(2, 1, 1, 16'hBEEF, 16'h1234, 0);
    xfer(3, 1, 0, 16'h8001, 16'hC0DE, 0);
    xfer(1, 1, 4, 16'h7E81, 16'hA55A, 0);
    xfer(3, 0, 1, 16'h00F0, 16'h000F, 0);
    // R3 write during busy
    xfer(0, 0, 3, 16'h003C, 16'h00E7, 1);
    xfer(2, 1, 2, 16'h1357, 16'h2468, 1);

    // R7 divider
    measure(0, 2);
    measure(1, 2);
    measure(5, 6);

    // R10 interrupt
    bus_wr(A_CTRL, ctrl_word(1, 0, 0, 1, 0, 3));
    repeat (2) @(negedge clk);
    chk(irq == 1, "R10 ready irq when idle", irq, 1);
    arm(0, 0, 16'h11);
    bus_wr(A_DATA, 16'h22);
    repeat (3) @(negedge clk);
    chk(irq == 0, "R10 ready irq low while busy", irq, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq == 1, "R10 ready irq back", irq, 1);
    bus_wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0, 3));
    repeat (2) @(negedge clk);
    chk(irq == 1, "R10 rx irq with rbf", irq, 1);
    bus_rd(A_DATA, d);
    chk(d == 16'h0011, "R8 rx word", d, 16'h0011);
    repeat (2) @(negedge clk);
    chk(irq == 0, "R10 rx irq cleared", irq, 0);

    // R9 abort
    bus_wr(A_CTRL, ctrl_word(1, 1, 0, 0, 2, 7));
    arm(2, 1, 16'hFFFF);
    bus_wr(A_DATA, 16'h0F0F);
    repeat (20) @(negedge clk);
    bus_rd(A_STAT, d); chk(d == 16'h1, "R2 busy during transfer", d, 1);
    bus_wr(A_CTRL, ctrl_word(0, 1, 0, 0, 2, 7));
    repeat (2) @(negedge clk);
    chk(sclk == 1, "R9 sclk idle after abort", sclk, 1);
    bus_rd(A_STAT, d); chk(d == 0, "R9 no busy no rbf", d, 0);
    bus_wr(A_DATA, 16'h1234);
    repeat (8) @(negedge clk);
    bus_rd(A_STAT, d); chk(d == 0, "R2 disabled write no start", d, 0);
    chk(sclk == 1, "R9 sclk stays idle", sclk, 1);

    finish_run();
  end
endmodule